// File: doc/BRIEF.md
# Power Management Control and Status Register

This block holds the power management control and status word of a PCI function. A register port reads and writes the 32-bit word with byte enables. The block keeps three pieces of state: a wake-event status flag, a wake-event enable flag and a two-bit device power state. It watches a level-sensitive wake-event source. It drives an active-low wake request pin, the current power state and a request to power down the PHY.

The status flag follows the event source. Software clears it by writing one, but the clear does not take effect while the source is still high. The status and enable flags are sticky when auxiliary power is present. In that case they survive a bus reset and only power-on reset clears them. Without auxiliary power, either reset clears them. Fields that are not implemented read as zero. All resets are synchronous and active high.

Top module: `pm_csr_ctrl`

## Requirements
- R1: Bits 31:16, 14:9 and 7:2 always read as zero and ignore writes.
- R2: The cycle after `pme_src` is high, bit 15 (status) reads 1.
- R3: A write with byte 1 enabled and bit 15 at 1 clears the status bit only when `pme_src` is low in that cycle. If `pme_src` is high, the status bit stays 1. A write with bit 15 at 0 leaves the status bit unchanged.
- R4: Bit 8 (enable) takes the written value on a write with byte 1 enabled.
- R5: `wake_n` is 0 one cycle after status and enable are both 1, and 1 otherwise.
- R6: When `aux_det` is 0, `bus_rst` clears bits 15 and 8.
- R7: When `aux_det` is 1, `bus_rst` leaves bits 15 and 8 unchanged, and `por_rst` still clears them.
- R8: Bits 1:0 hold the power state, with 00 meaning D0 and 11 meaning D3hot. Writing 01 or 10 leaves the field unchanged. `bus_rst` and `por_rst` both return it to 00. `pwr_state` mirrors the field.
- R9: When the power state enters D3hot and enable is 0, `phy_pd_req` rises in the same cycle. It stays high while the state is D3hot, drops when the state returns to D0, and is not raised when enable is 1.
- R10: A write changes only the bytes whose `wr_be` bit is 1. Byte 0 holds bits 1:0, and byte 1 holds bits 15 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| bus_rst | input | 1 | Bus reset, synchronous, active high |
| aux_det | input | 1 | Auxiliary power present |
| pme_src | input | 1 | Wake-event source, level sensitive |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables for the write |
| rd_data | output | 32 | Current register word |
| wake_n | output | 1 | Wake request, active low, registered |
| pwr_state | output | 2 | Current device power state |
| phy_pd_req | output | 1 | PHY power-down request, registered |

## Verification
If the status or enable flag is wrong, it shows on `rd_data` in the cycle after the event or write. It then shows on `wake_n` one cycle later. If the reset-domain selection is wrong, the flags are lost or kept after a single bus reset cycle, and this is visible on the next read. If the power state or PHY request bookkeeping is wrong, it shows on `pwr_state` and `phy_pd_req` at the same edge as the write that moves the state.

// File: rtl/pm_csr_pkg.sv
package pm_csr_pkg;
  localparam int CSR_W    = 32;
  localparam int BIT_STAT = 15;
  localparam int BIT_EN   = 8;
  localparam int ST_W     = 2;

  typedef enum logic [ST_W-1:0] {
    PS_D0    = 2'b00,
    PS_D1    = 2'b01,
    PS_D2    = 2'b10,
    PS_D3HOT = 2'b11
  } pstate_t;

  function automatic logic state_ok(input logic [ST_W-1:0] s);
    return (s == PS_D0) || (s == PS_D3HOT);
  endfunction
endpackage

// File: rtl/pme_stat_cell.sv
module pme_stat_cell (
  input  logic clk,
  input  logic rst_sticky,
  input  logic evt_in,
  input  logic clr_req,
  output logic stat_q
);
  always_ff @(posedge clk) begin
    if (rst_sticky)   stat_q <= 1'b0;
    else if (evt_in)  stat_q <= 1'b1;
    else if (clr_req) stat_q <= 1'b0;
  end
endmodule

// File: rtl/pm_state_cell.sv
module pm_state_cell
  import pm_csr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_sticky,
  input  logic            rst_any,
  input  logic            en_wr,
  input  logic            en_val,
  input  logic            st_wr,
  input  logic [ST_W-1:0] st_val,
  output logic            en_q,
  output logic [ST_W-1:0] state_q,
  output logic            phy_pd_q
);
  logic            en_nxt;
  logic [ST_W-1:0] st_nxt;
  logic            pd_nxt;

  always_comb begin
    en_nxt = en_wr ? en_val : en_q;
    st_nxt = (st_wr && state_ok(st_val)) ? st_val : state_q;
    pd_nxt = phy_pd_q;
    if (st_nxt == PS_D0)
      pd_nxt = 1'b0;
    else if (st_nxt == PS_D3HOT && state_q != PS_D3HOT && !en_nxt)
      pd_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_sticky) en_q <= 1'b0;
    else            en_q <= en_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      state_q  <= PS_D0;
      phy_pd_q <= 1'b0;
    end else begin
      state_q  <= st_nxt;
      phy_pd_q <= pd_nxt;
    end
  end
endmodule

// File: rtl/pm_wake_drv.sv
module pm_wake_drv (
  input  logic clk,
  input  logic rst_sticky,
  input  logic stat,
  input  logic en,
  output logic wake_n
);
  always_ff @(posedge clk) begin
    if (rst_sticky) wake_n <= 1'b1;
    else            wake_n <= ~(stat & en);
  end
endmodule

// File: rtl/pm_csr_ctrl.sv
module pm_csr_ctrl
  import pm_csr_pkg::*;
#(
  parameter int DATA_W = CSR_W,
  localparam int NBYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              bus_rst,
  input  logic              aux_det,
  input  logic              pme_src,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NBYTES-1:0] wr_be,
  output logic [DATA_W-1:0] rd_data,
  output logic              wake_n,
  output logic [ST_W-1:0]   pwr_state,
  output logic              phy_pd_req
);
  localparam int BYTE_EN_IDX = BIT_EN / 8;
  localparam int BYTE_ST_IDX = BIT_STAT / 8;

  logic [NBYTES-1:0] byte_wr;
  logic rst_sticky, rst_any;
  logic stat_q, en_q;
  logic [ST_W-1:0] state_q;

  genvar b;
  generate
    for (b = 0; b < NBYTES; b++) begin : g_bwr
      assign byte_wr[b] = wr_en & wr_be[b];
    end
  endgenerate

  assign rst_sticky = por_rst | (bus_rst & ~aux_det);
  assign rst_any    = por_rst | bus_rst;

  pme_stat_cell u_stat (
    .clk        (clk),
    .rst_sticky (rst_sticky),
    .evt_in     (pme_src),
    .clr_req    (byte_wr[BYTE_ST_IDX] & wr_data[BIT_STAT]),
    .stat_q     (stat_q)
  );

  pm_state_cell u_state (
    .clk        (clk),
    .rst_sticky (rst_sticky),
    .rst_any    (rst_any),
    .en_wr      (byte_wr[BYTE_EN_IDX]),
    .en_val     (wr_data[BIT_EN]),
    .st_wr      (byte_wr[0]),
    .st_val     (wr_data[ST_W-1:0]),
    .en_q       (en_q),
    .state_q    (state_q),
    .phy_pd_q   (phy_pd_req)
  );

  pm_wake_drv u_wake (
    .clk        (clk),
    .rst_sticky (rst_sticky),
    .stat       (stat_q),
    .en         (en_q),
    .wake_n     (wake_n)
  );

  always_comb begin
    rd_data              = '0;
    rd_data[BIT_STAT]    = stat_q;
    rd_data[BIT_EN]      = en_q;
    rd_data[ST_W-1:0]    = state_q;
  end

  assign pwr_state = state_q;
endmodule

// File: rtl/pm_csr_ctrl_chk.sv
module pm_csr_ctrl_chk (
  input logic        clk,
  input logic        por_rst,
  input logic        bus_rst,
  input logic        aux_det,
  input logic        pme_src,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [3:0]  wr_be,
  input logic [31:0] rd_data,
  input logic        wake_n,
  input logic [1:0]  pwr_state,
  input logic        phy_pd_req
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (por_rst)
    (rd_data & 32'hFFFF_7EFC) == 32'h0); // R1
  AST_STAT_SET: assert property (@(posedge clk) disable iff (por_rst || bus_rst)
    pme_src |=> rd_data[15]); // R2
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (por_rst || bus_rst)
    (rd_data[15] && !(wr_en && wr_be[1] && wr_data[15])) |=> rd_data[15]); // R3
  AST_WAKE_ON: assert property (@(posedge clk) disable iff (por_rst || bus_rst)
    (rd_data[15] && rd_data[8]) |=> !wake_n); // R5
  AST_AUX_KEEP: assert property (@(posedge clk) disable iff (por_rst)
    (aux_det && bus_rst && rd_data[8] && !(wr_en && wr_be[1])) |=> rd_data[8]); // R7
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (por_rst)
    (pwr_state == 2'b00) || (pwr_state == 2'b11)); // R8
  AST_PD_D0: assert property (@(posedge clk) disable iff (por_rst)
    (pwr_state == 2'b00) |-> !phy_pd_req); // R9
endmodule

bind pm_csr_ctrl pm_csr_ctrl_chk u_chk (
  .clk(clk), .por_rst(por_rst), .bus_rst(bus_rst), .aux_det(aux_det),
  .pme_src(pme_src), .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
  .rd_data(rd_data), .wake_n(wake_n), .pwr_state(pwr_state),
  .phy_pd_req(phy_pd_req)
);

// File: tb/pm_csr_ctrl_tb.sv
module pm_csr_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        por_rst = 1'b1, bus_rst = 1'b0, aux_det = 1'b0, pme_src = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] rd_data;
  logic        wake_n, phy_pd_req;
  logic [1:0]  pwr_state;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pm_csr_ctrl dut_i (
    .clk(clk), .por_rst(por_rst), .bus_rst(bus_rst), .aux_det(aux_det),
    .pme_src(pme_src), .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
    .rd_data(rd_data), .wake_n(wake_n), .pwr_state(pwr_state),
    .phy_pd_req(phy_pd_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] be);
    wr_en = 1'b1; wr_data = d; wr_be = be;
    tick();
    wr_en = 1'b0; wr_data = '0; wr_be = '0;
  endtask

  task automatic pulse_bus_rst();
    bus_rst = 1'b1; tick(); bus_rst = 1'b0;
  endtask

  task automatic t_reset();
    por_rst = 1'b1; tick(2); por_rst = 1'b0;
    check("R8 reset word", rd_data, 32'h0);
    check("R5 reset wake_n", {31'b0, wake_n}, 32'h1);
    check("R9 reset pd", {31'b0, phy_pd_req}, 32'h0);
  endtask

  task automatic t_status();
    pme_src = 1'b1; tick();
    check("R2 status set", {31'b0, rd_data[15]}, 32'h1);
    wr(32'h0000_8000, 4'b0010);
    check("R3 set wins over clear", {31'b0, rd_data[15]}, 32'h1);
    pme_src = 1'b0;
    wr(32'h0000_0000, 4'b0010);
    check("R3 write 0 no effect", {31'b0, rd_data[15]}, 32'h1);
    wr(32'h0000_8000, 4'b0001);
    check("R10 byte1 disabled keeps status", {31'b0, rd_data[15]}, 32'h1);
    wr(32'h0000_8000, 4'b0010);
    check("R3 clear when source low", {31'b0, rd_data[15]}, 32'h0);
  endtask

  task automatic t_enable_wake();
    pme_src = 1'b1; tick(); pme_src = 1'b0;
    wr(32'h0000_0100, 4'b0010);
    check("R4 enable set", {31'b0, rd_data[8]}, 32'h1);
    check("R5 wake not yet", {31'b0, wake_n}, 32'h1);
    tick();
    check("R5 wake asserted", {31'b0, wake_n}, 32'h0);
    wr(32'h0000_0000, 4'b0010);
    tick();
    check("R4 enable cleared", {31'b0, rd_data[8]}, 32'h0);
    check("R5 wake released", {31'b0, wake_n}, 32'h1);
  endtask

  task automatic t_bus_rst_aux();
    wr(32'h0000_0100, 4'b0010);
    pme_src = 1'b1; tick(); pme_src = 1'b0;
    aux_det = 1'b1; pulse_bus_rst();
    check("R7 aux keeps bits", rd_data & 32'h0000_8100, 32'h0000_8100);
    por_rst = 1'b1; tick(); por_rst = 1'b0;
    check("R7 por clears bits", rd_data & 32'h0000_8100, 32'h0);
    aux_det = 1'b0;
  endtask

  task automatic t_bus_rst_noaux();
    wr(32'h0000_0103, 4'b0011);
    pme_src = 1'b1; tick(); pme_src = 1'b0;
    check("R8 state D3hot", {30'b0, pwr_state}, 32'h3);
    pulse_bus_rst();
    check("R6 bus reset clears", rd_data & 32'h0000_8100, 32'h0);
    check("R8 bus reset to D0", {30'b0, pwr_state}, 32'h0);
  endtask

  task automatic t_state();
    wr(32'h0000_0003, 4'b0001);
    wr(32'h0000_0001, 4'b0001);
    check("R8 code 01 ignored", {30'b0, pwr_state}, 32'h3);
    wr(32'h0000_0002, 4'b0001);
    check("R8 code 10 ignored", rd_data[1:0], 2'b11);
    wr(32'h0000_0000, 4'b0001);
    check("R8 back to D0", {30'b0, pwr_state}, 32'h0);
  endtask

  task automatic t_phy_pd();
    wr(32'h0000_0003, 4'b0001);
    check("R9 pd on D3 entry", {31'b0, phy_pd_req}, 32'h1);
    wr(32'h0000_0001, 4'b0001);
    check("R9 pd held", {31'b0, phy_pd_req}, 32'h1);
    wr(32'h0000_0000, 4'b0001);
    check("R9 pd released at D0", {31'b0, phy_pd_req}, 32'h0);
    wr(32'h0000_0100, 4'b0010);
    wr(32'h0000_0003, 4'b0001);
    check("R9 no pd when enabled", {31'b0, phy_pd_req}, 32'h0);
    wr(32'h0000_0000, 4'b0011);
  endtask

  task automatic t_reserved();
    pme_src = 1'b1; tick(); pme_src = 1'b0;
    wr(32'hFFFF_FFFF, 4'b1111);
    check("R1 reserved zero", rd_data, 32'h0000_0103);
    wr(32'hFFFF_FEFC, 4'b0001);
    check("R10 byte0 only", rd_data, 32'h0000_0100);
    wr(32'h0000_0000, 4'b0011);
  endtask

  initial begin
    t_reset();
    t_status();
    t_enable_wake();
    t_bus_rst_aux();
    t_bus_rst_noaux();
    t_state();
    t_phy_pd();
    t_reserved();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule